// File: doc/BRIEF.md
# SIMD Saturating Rounding Doubling Multiply-Subtract Unit

This unit applies one signed scalar to every signed lane of a source vector. The scalar is picked by index from a second vector. Each product is doubled and subtracted from the matching accumulator lane, and the accumulator lane is first moved into the upper half of a double-width word. The difference is rounded, its upper half is kept, and that value is clamped to the lane width. The whole subtraction is done at full precision. Rounding and clamping happen only once, at the very end.

Lanes are 16 or 32 bits wide. The operation covers either the low 64 bits or the full 128 bits of the vectors. A scalar mode computes lane 0 only. An operation enters with `in_valid` and leaves two clock cycles later on `out_valid`, and the unit never stalls. A sticky flag records that some lane of some operation was clamped. The flag stays set until `sat_clr` is pulsed.

Top module: `simd_qrdmsub_unit`

## Requirements
- R1: For each active lane of width E, the result is floor(((acc << E) - 2*a*b + 2^(E-1)) / 2^E). Here a is the source lane and b is the scalar, and the arithmetic is exact with no intermediate truncation.
- R2: A lane value above 2^(E-1)-1 or below -2^(E-1) is clamped to that limit. `sat_now` is high together with `out_valid` exactly when any active lane of that operation was clamped. A lane with a = b = acc = -2^(E-1) gives -2^(E-1) and is counted as clamped.
- R3: `sat_sticky` goes high on the same edge as a clamping result. It then stays high until the cycle after `sat_clr` is asserted. If a clamp and `sat_clr` coincide, the set wins.
- R4: `size_code` 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Codes 2'b00 and 2'b11 are illegal. For an illegal code, `illegal_op` pulses two cycles after `in_valid`, `out_valid` stays low, and `result` and `sat_sticky` keep their values.
- R5: With `wide`=0 only the low 64 bits are computed (4x16 or 2x32 lanes) and bits 127:64 of `result` are zero. With `wide`=1 all 128 bits are computed.
- R6: With `scalar_mode`=1 only lane 0 is computed. All result bits above lane 0 are zero.
- R7: The scalar is `src_b[k*E +: E]`. For 16-bit lanes k = `lane_idx[2:0]`. For 32-bit lanes k = `lane_idx[1:0]`, and `lane_idx[2]` is ignored.
- R8: `out_valid` rises exactly two clock edges after `in_valid` is sampled with a legal size code. It is a one-cycle pulse for each accepted operation.
- R9: Synchronous active-high `rst` clears `out_valid`, `illegal_op`, `sat_now`, `sat_sticky` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| size_code | input | 2 | Lane size code (01 = 16-bit, 10 = 32-bit) |
| wide | input | 1 | 0 = 64-bit vector, 1 = 128-bit vector |
| scalar_mode | input | 1 | Compute lane 0 only |
| lane_idx | input | 3 | Scalar lane index into src_b |
| src_a | input | 128 | Multiplicand vector |
| src_b | input | 128 | Vector holding the scalar operand |
| acc_in | input | 128 | Accumulator vector |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid pulse |
| result | output | 128 | Result vector |
| sat_now | output | 1 | Some lane of this result was clamped |
| sat_sticky | output | 1 | Cumulative saturation flag |
| illegal_op | output | 1 | Pulse for an operation with a reserved size code |

## Verification
The hardest case to reach from the ports is a clamp caused only by the subtraction itself. This happens when the accumulator sits at one limit and the doubled product pushes the exact value past the other side, which includes the all-minimum lane. It also covers the round-half-up boundary, where a value sits exactly halfway between two results. The stimulus table places these values in selected lanes, with the scalar taken from several indices. Every other lane keeps ordinary values, so a wrong lane mask or a wrong index shows up in the same result. A 70-bit integer model in the bench supplies the expected lanes.

// File: rtl/simd_qrdm_pkg.sv
package simd_qrdm_pkg;
  localparam int E16 = 16;
  localparam int E32 = 32;
  localparam logic [1:0] SZ_16 = 2'b01;
  localparam logic [1:0] SZ_32 = 2'b10;
endpackage

// File: rtl/qrdm_scalar_pick.sv
module qrdm_scalar_pick #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] src_b,
  input  logic [2:0]       idx,
  output logic [15:0]      b16,
  output logic [31:0]      b32
);
  logic [6:0] base16;
  logic [6:0] base32;
  always_comb begin
    base16 = {idx, 4'b0000};
    base32 = {idx[1:0], 5'b00000};
    b16 = src_b[base16 +: 16];
    b32 = src_b[base32 +: 32];
  end
endmodule

// File: rtl/qrdm_lane_fin.sv
module qrdm_lane_fin #(
  parameter int E = 16
) (
  input  logic signed [E-1:0]   acc,
  input  logic signed [2*E-1:0] prod,
  output logic [E-1:0]          res,
  output logic                  sat
);
  localparam int W = 2 * E + 2;
  localparam logic signed [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic signed [W-1:0] MAXV = (ONE <<< (E - 1)) - ONE;
  localparam logic signed [W-1:0] MINV = -MAXV - ONE;
  localparam logic signed [W-1:0] RND  = ONE <<< (E - 1);

  logic signed [W-1:0] acc_x, prod_x, diff, shr;

  always_comb begin
    acc_x  = {{2{acc[E-1]}}, acc, {E{1'b0}}};
    prod_x = {prod[2*E-1], prod, 1'b0};
    diff   = acc_x - prod_x + RND;
    shr    = diff >>> E;
    if (shr > MAXV) begin
      res = MAXV[E-1:0];
      sat = 1'b1;
    end else if (shr < MINV) begin
      res = MINV[E-1:0];
      sat = 1'b1;
    end else begin
      res = shr[E-1:0];
      sat = 1'b0;
    end
  end
endmodule

// File: rtl/simd_qrdmsub_unit.sv
module simd_qrdmsub_unit
  import simd_qrdm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       size_code,
  input  logic             wide,
  input  logic             scalar_mode,
  input  logic [2:0]       lane_idx,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc_in,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_now,
  output logic             sat_sticky,
  output logic             illegal_op
);
  localparam int L16 = VEC_W / E16;
  localparam int L32 = VEC_W / E32;

  logic [15:0] b16;
  logic [31:0] b32;

  qrdm_scalar_pick #(.VEC_W(VEC_W)) pick_i (
    .src_b(src_b), .idx(lane_idx), .b16(b16), .b32(b32)
  );

  // stage 1: products
  logic             v1, legal1, e32_1, wide1, scal1;
  logic [VEC_W-1:0] acc1;
  logic signed [31:0] p16 [L16];
  logic signed [63:0] p32 [L32];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
    end else begin
      v1 <= in_valid;
    end
    legal1 <= (size_code == SZ_16) || (size_code == SZ_32);
    e32_1  <= (size_code == SZ_32);
    wide1  <= wide;
    scal1  <= scalar_mode;
    acc1   <= acc_in;
  end

  genvar gi;
  generate
    for (gi = 0; gi < L16; gi++) begin : g_mul16
      always_ff @(posedge clk)
        p16[gi] <= $signed(src_a[gi*E16 +: E16]) * $signed(b16);
    end
    for (gi = 0; gi < L32; gi++) begin : g_mul32
      always_ff @(posedge clk)
        p32[gi] <= $signed(src_a[gi*E32 +: E32]) * $signed(b32);
    end
  endgenerate

  // stage 2: subtract, round, clamp
  logic [L16-1:0]   sat16, act16;
  logic [L32-1:0]   sat32, act32;
  logic [VEC_W-1:0] r16, r32;

  generate
    for (gi = 0; gi < L16; gi++) begin : g_fin16
      logic [E16-1:0] lr;
      qrdm_lane_fin #(.E(E16)) fin_i (
        .acc(acc1[gi*E16 +: E16]), .prod(p16[gi]), .res(lr), .sat(sat16[gi])
      );
      assign act16[gi] = scal1 ? (gi == 0) : (wide1 || (gi < L16 / 2));
      assign r16[gi*E16 +: E16] = act16[gi] ? lr : '0;
    end
    for (gi = 0; gi < L32; gi++) begin : g_fin32
      logic [E32-1:0] lr;
      qrdm_lane_fin #(.E(E32)) fin_i (
        .acc(acc1[gi*E32 +: E32]), .prod(p32[gi]), .res(lr), .sat(sat32[gi])
      );
      assign act32[gi] = scal1 ? (gi == 0) : (wide1 || (gi < L32 / 2));
      assign r32[gi*E32 +: E32] = act32[gi] ? lr : '0;
    end
  endgenerate

  logic [VEC_W-1:0] res_nx;
  logic             sat_nx, take;
  always_comb begin
    res_nx = e32_1 ? r32 : r16;
    sat_nx = e32_1 ? |(sat32 & act32) : |(sat16 & act16);
    take   = v1 && legal1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      illegal_op <= 1'b0;
      sat_now    <= 1'b0;
      sat_sticky <= 1'b0;
      result     <= '0;
    end else begin
      out_valid  <= take;
      illegal_op <= v1 && !legal1;
      sat_now    <= take && sat_nx;
      if (take) result <= res_nx;
      if (take && sat_nx) sat_sticky <= 1'b1;
      else if (sat_clr)   sat_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/qrdm_chk.sv
module qrdm_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   size_code,
  input logic         wide,
  input logic         scalar_mode,
  input logic         sat_clr,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         sat_now,
  input logic         sat_sticky,
  input logic         illegal_op
);
  logic legal_in;
  assign legal_in = (size_code == 2'b01) || (size_code == 2'b10);

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal_in) |=> ##1 out_valid);

  a_r4_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal_in) |=> ##1 (illegal_op && !out_valid));

  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    (illegal_op && !out_valid) |-> $stable(result));

  a_r3_set_with_sat: assert property (@(posedge clk) disable iff (rst)
    sat_now |-> sat_sticky);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (sat_sticky && !sat_clr) |=> sat_sticky);

  a_r2_sat_needs_valid: assert property (@(posedge clk) disable iff (rst)
    sat_now |-> out_valid);

  a_r5_half_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(wide, 2)) |-> (result[127:64] == '0));

  a_r6_scalar_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(scalar_mode, 2)) |-> (result[127:32] == '0));
endmodule

bind simd_qrdmsub_unit qrdm_chk chk_i (.*);

// File: tb/simd_qrdmsub_unit_tb_top.sv
`timescale 1ns/1ps
module simd_qrdmsub_unit_tb_top;
  typedef struct packed {
    logic [1:0]   sz;
    logic         wd;
    logic         sc;
    logic [2:0]   ix;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] c;
  } stim_t;

  localparam int NT = 9;
  localparam stim_t TAB [NT] = '{
    '{2'b01, 1'b1, 1'b0, 3'd3, 128'h0001_4000_C000_7FFF_8000_1234_FEDC_0100,
      128'h1111_2222_3333_0001_5555_6666_7777_8888, 128'h0000_0000_0000_1000_F000_0ABC_8001_7FFE},
    '{2'b01, 1'b0, 1'b0, 3'd7, 128'hAAAA_BBBB_CCCC_DDDD_0102_F0F0_7FFF_8001,
      128'h7000_0000_0000_0000_0000_0000_0000_0000, 128'h5555_6666_7777_8888_1234_8000_7FFF_0000},
    '{2'b10, 1'b1, 1'b0, 3'd2, 128'h12345678_9ABCDEF0_7FFFFFFF_80000001,
      128'h00000001_C0000000_00000000_00000000, 128'h0000FFFF_80000000_7FFFFFFF_11111111},
    '{2'b10, 1'b0, 1'b0, 3'd5, 128'h11111111_22222222_40000000_C0000000,
      128'h00000000_00000000_00000002_00000000, 128'hDEADBEEF_01234567_00000000_00000000},
    '{2'b01, 1'b1, 1'b1, 3'd5, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_4321,
      128'h0000_0000_8765_0000_0000_0000_0000_0000, 128'h1111_1111_1111_1111_1111_1111_1111_0F0F},
    '{2'b10, 1'b1, 1'b1, 3'd3, 128'h7FFFFFFF_7FFFFFFF_7FFFFFFF_7FFFFFFF,
      128'h80000000_00000000_00000000_00000000, 128'h7FFFFFFF_7FFFFFFF_7FFFFFFF_7FFFFFFF},
    '{2'b01, 1'b1, 1'b0, 3'd0, 128'h0000_0000_0000_0000_0000_0000_0000_8000,
      128'h0000_0000_0000_0000_0000_0000_0000_7FFF, 128'h0000_0000_0000_0000_0000_0000_0000_7FFF},
    '{2'b01, 1'b1, 1'b0, 3'd1, 128'h8000_8000_8000_8000_8000_8000_8000_8000,
      128'h0000_0000_0000_0000_0000_0000_8000_0000, 128'h8000_8000_8000_8000_8000_8000_8000_8000},
    '{2'b10, 1'b1, 1'b0, 3'd0, 128'h80000000_80000000_80000000_80000000,
      128'h00000000_00000000_00000000_80000000, 128'h80000000_80000000_80000000_80000000}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, in_valid, wide, scalar_mode, sat_clr;
  logic [1:0]   size_code;
  logic [2:0]   lane_idx;
  logic [127:0] src_a, src_b, acc_in;
  logic         out_valid, sat_now, sat_sticky, illegal_op;
  logic [127:0] result;

  simd_qrdmsub_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code), .wide(wide),
    .scalar_mode(scalar_mode), .lane_idx(lane_idx), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .sat_clr(sat_clr), .out_valid(out_valid), .result(result),
    .sat_now(sat_now), .sat_sticky(sat_sticky), .illegal_op(illegal_op)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // integer reference: R1, R2, R5, R6, R7
  task automatic model(input stim_t s, output logic [127:0] r, output logic st);
    int e, n, k;
    logic [127:0] bs;
    logic signed [69:0] av, bv, cv, x, mx, mn;
    e = (s.sz == 2'b01) ? 16 : 32;
    n = s.sc ? 1 : ((s.wd ? 128 : 64) / e);
    k = (e == 16) ? int'(s.ix) : int'(s.ix[1:0]);
    bs = s.b >> (k * e);
    bv = (e == 16) ? 70'(signed'(bs[15:0])) : 70'(signed'(bs[31:0]));
    mx = (70'sd1 <<< (e - 1)) - 70'sd1;
    mn = -mx - 70'sd1;
    r = '0;
    st = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [127:0] as, cs;
      as = s.a >> (i * e);
      cs = s.c >> (i * e);
      av = (e == 16) ? 70'(signed'(as[15:0])) : 70'(signed'(as[31:0]));
      cv = (e == 16) ? 70'(signed'(cs[15:0])) : 70'(signed'(cs[31:0]));
      x = ((cv <<< e) - 70'sd2 * av * bv + (70'sd1 <<< (e - 1))) >>> e;
      if (x > mx) begin x = mx; st = 1'b1; end
      if (x < mn) begin x = mn; st = 1'b1; end
      if (e == 16) r[i*16 +: 16] = x[15:0];
      else         r[i*32 +: 32] = x[31:0];
    end
  endtask

  task automatic issue(input stim_t s);
    @(negedge clk);
    in_valid = 1'b1; size_code = s.sz; wide = s.wd; scalar_mode = s.sc;
    lane_idx = s.ix; src_a = s.a; src_b = s.b; acc_in = s.c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] er, keep;
    logic es;
    stim_t s;
    rst = 1'b1; in_valid = 1'b0; size_code = 2'b01; wide = 1'b0; scalar_mode = 1'b0;
    lane_idx = '0; src_a = '0; src_b = '0; acc_in = '0; sat_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", 128'(out_valid), 128'd0);
    chk("R9 result", result, 128'd0);
    chk("R9 sticky", 128'(sat_sticky), 128'd0);
    rst = 1'b0;

    // table walk: R1 R2 R5 R6 R7 R8
    for (int t = 0; t < NT; t++) begin
      model(TAB[t], er, es);
      issue(TAB[t]);
      chk("R8 not early", 128'(out_valid), 128'd0);
      @(negedge clk);
      chk("R8 valid at 2", 128'(out_valid), 128'd1);
      chk("R1 result", result, er);
      chk("R2 sat_now", 128'(sat_now), 128'(es));
      @(negedge clk);
      chk("R8 single pulse", 128'(out_valid), 128'd0);
    end

    // R3: sticky held after saturating table rows, cleared by sat_clr
    chk("R3 sticky set", 128'(sat_sticky), 128'd1);
    s = TAB[0];
    model(s, er, es);
    issue(s); @(negedge clk);
    chk("R3 sticky held", 128'(sat_sticky), 128'd1);
    sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0;
    chk("R3 sticky cleared", 128'(sat_sticky), 128'd0);

    // R3: set wins over clear in same cycle
    s = TAB[7];
    issue(s);
    sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0;
    chk("R3 set beats clear", 128'(sat_sticky), 128'd1);
    sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0;

    // R4: illegal size codes keep result and sticky
    keep = result;
    s = TAB[7]; s.sz = 2'b00;
    issue(s); @(negedge clk);
    chk("R4 illegal pulse", 128'(illegal_op), 128'd1);
    chk("R4 no valid", 128'(out_valid), 128'd0);
    chk("R4 result kept", result, keep);
    chk("R4 sticky kept", 128'(sat_sticky), 128'd0);
    s.sz = 2'b11;
    issue(s); @(negedge clk);
    chk("R4 illegal code 11", 128'(illegal_op), 128'd1);
    chk("R4 result kept 11", result, keep);
    chk("R4 sticky kept 11", 128'(sat_sticky), 128'd0);

    // R9: reset clears sticky
    issue(TAB[8]); @(negedge clk);
    chk("R2 min corner 32", 128'(sat_sticky), 128'd1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R9 sticky reset", 128'(sat_sticky), 128'd0);
    chk("R9 result reset", result, 128'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule